// File: doc/BRIEF.md
# Multiplexed LED Matrix PWM Scanner

This block drives a time-multiplexed LED matrix of scan lines and current-sink columns (by default 4 lines by 18 columns, 72 dots). Only one line is switched on at a time; the same column sink enables serve each line in turn. Every dot has its own PWM duty, an 8-bit current-gain code and an optional group mapping. A mapped dot's duty is scaled by one of several shared 8-bit group duties, so a whole group can be dimmed with a single write.

Within each line slot a counter runs one full PWM period, 8-bit or 16-bit wide depending on a mode bit. A short blanking gap follows before the next line. The column enables and the gain codes for the active line come out combinationally from the scan state. A write port fills shadow storage. The shadow values reach the scan only at a frame boundary, or at once while the block is disabled, so a frame never mixes old and new data.

Top module: `led_matrix_scanner`

## Requirements
- R1: `line_on` is one-hot or zero. Lines are visited in the order 0,1,2,3,0,... Each line stays on for exactly 2^W consecutive cycles, where W is the active PWM width.
- R2: After each line slot, exactly BLANK cycles follow in which `line_on`, `sink_on` and `sink_gain` are all zero.
- R3: In cycle k of a slot (k counted from 0), `sink_on[c]` is 1 exactly when k is less than the effective duty of dot line*COLS+c. For a dot with group code 0 the effective duty is its own duty.
- R4: A dot with group code g in 1..NGRP has effective duty (d * G[g]) >> 8, where d is its duty and G[g] is the 8-bit duty of group g.
- R5: Mode bit 0 selects the width: 1 gives HI_W bits and a 2^HI_W slot, 0 gives LO_W bits and a 2^LO_W slot. In LO_W mode only the low LO_W bits of each duty are used.
- R6: A dot whose effective duty is 0 never has its sink enabled.
- R7: While a line is on, `sink_gain[8c+7:8c]` carries the gain code of dot line*COLS+c. Otherwise it is zero.
- R8: Writes change shadow values only. The scan uses them from the cycle that follows the last blanking cycle of line LINES-1. A write in that same cycle is held until the next boundary.
- R9: While `en` is 0, all outputs are zero and the shadow values are copied to the active values every cycle. After `en` rises, the scan starts at line 0 with count 0.
- R10: After reset, all outputs are zero. All stored values are zero and the mode is LO_W.
- R11: `wr_addr` is {region[1:0], index}. The regions are: 0 for dot duty (data[HI_W-1:0]), 1 for dot gain (data[7:0]) and 2 for dot group code (data[GRP_W-1:0]). Region 3 takes the mode at index 0 (data[0]) and the duty of group g at index g (data[7:0]). A dot index of DOTS or more, or a region-3 index above NGRP, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Global scan enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2+IDX_W | Region and index of the write |
| wr_data | input | max(HI_W,8) | Write data |
| line_on | output | LINES | One-hot scan line switch |
| sink_on | output | COLS | Column sink enables for the active line |
| sink_gain | output | 8*COLS | Per-column current-gain codes |

## Verification
The hardest situation to reach is a write that lands in the middle of a frame, and one that lands in the very cycle the frame rolls over. These are where tearing or an off-by-one commit would show. The bench runs a small configuration (2-bit and 4-bit widths, 2 blanking cycles), so whole frames take only tens of cycles. It issues back-to-back writes at many offsets inside running frames, including across the rollover. A cycle-level model in the bench predicts every output bit on every cycle, using the commit rule, the group arithmetic and the width-mode switch.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
   localparam int GAIN_W  = 8;
   localparam int GDUTY_W = 8;

   typedef enum logic [1:0] {
      REG_DUTY  = 2'd0,
      REG_GAIN  = 2'd1,
      REG_GROUP = 2'd2,
      REG_CTRL  = 2'd3
   } reg_region_e;
endpackage

// File: rtl/lsc_regfile.sv
// Shadow and active storage for dot data, group duties and mode.
module lsc_regfile
   import lsc_pkg::*;
#(
   parameter int DOTS  = 72,
   parameter int IDX_W = 7,
   parameter int HI_W  = 16,
   parameter int WD_W  = 16,
   parameter int NGRP  = 3,
   parameter int GRP_W = 2,
   localparam int GI_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  reg_region_e         wr_region,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [WD_W-1:0]     wr_data,
   input  logic                commit,
   output logic [HI_W-1:0]     act_duty  [DOTS],
   output logic [GAIN_W-1:0]   act_gain  [DOTS],
   output logic [GRP_W-1:0]    act_grp   [DOTS],
   output logic [GDUTY_W-1:0]  act_gduty [NGRP],
   output logic                act_wide
);

   logic [HI_W-1:0]    sh_duty  [DOTS];
   logic [GAIN_W-1:0]  sh_gain  [DOTS];
   logic [GRP_W-1:0]   sh_grp   [DOTS];
   logic [GDUTY_W-1:0] sh_gduty [NGRP];
   logic               sh_wide;

   logic               dot_ok;
   logic               grp_ok;
   logic [IDX_W-1:0]   gsel_full;
   logic [GI_W-1:0]    gsel;

   assign dot_ok    = (int'(wr_idx) < DOTS);
   assign grp_ok    = (wr_idx != '0) && (int'(wr_idx) <= NGRP);
   assign gsel_full = wr_idx - IDX_W'(1);
   assign gsel      = gsel_full[GI_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DOTS; i++) begin
            sh_duty[i] <= '0;
            sh_gain[i] <= '0;
            sh_grp[i]  <= '0;
         end
         for (int g = 0; g < NGRP; g++) sh_gduty[g] <= '0;
         sh_wide <= 1'b0;
      end else if (wr_en) begin
         case (wr_region)
            REG_DUTY:  if (dot_ok) sh_duty[wr_idx] <= wr_data[HI_W-1:0];
            REG_GAIN:  if (dot_ok) sh_gain[wr_idx] <= wr_data[GAIN_W-1:0];
            REG_GROUP: if (dot_ok) sh_grp[wr_idx]  <= wr_data[GRP_W-1:0];
            REG_CTRL: begin
               if (wr_idx == '0)  sh_wide        <= wr_data[0];
               else if (grp_ok)   sh_gduty[gsel] <= wr_data[GDUTY_W-1:0];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DOTS; i++) begin
            act_duty[i] <= '0;
            act_gain[i] <= '0;
            act_grp[i]  <= '0;
         end
         for (int g = 0; g < NGRP; g++) act_gduty[g] <= '0;
         act_wide <= 1'b0;
      end else if (commit) begin
         for (int i = 0; i < DOTS; i++) begin
            act_duty[i] <= sh_duty[i];
            act_gain[i] <= sh_gain[i];
            act_grp[i]  <= sh_grp[i];
         end
         for (int g = 0; g < NGRP; g++) act_gduty[g] <= sh_gduty[g];
         act_wide <= sh_wide;
      end
   end

   // Active values move only on a commit from the sequencer (R8).
   assert_hold_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(act_wide));
   assert_hold_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(act_gduty[0]));

endmodule

// File: rtl/lsc_sequencer.sv
// Line / PWM counter / blanking state machine.
module lsc_sequencer #(
   parameter int LINES = 4,
   parameter int LO_W  = 8,
   parameter int HI_W  = 16,
   parameter int BLANK = 4,
   localparam int LN_W = (LINES > 1) ? $clog2(LINES) : 1,
   localparam int BK_W = (BLANK > 1) ? $clog2(BLANK) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wide,
   output logic [LN_W-1:0]  line,
   output logic [HI_W-1:0]  cnt,
   output logic             active,
   output logic             frame_end
);

   localparam logic [HI_W-1:0] TOP_HI = '1;
   localparam logic [HI_W-1:0] TOP_LO = HI_W'((1 << LO_W) - 1);
   localparam logic [LN_W-1:0] LAST_LINE = LN_W'(LINES - 1);
   localparam logic [BK_W-1:0] LAST_BLK  = BK_W'(BLANK - 1);

   logic [LN_W-1:0] line_q;
   logic [HI_W-1:0] cnt_q;
   logic [BK_W-1:0] bcnt_q;
   logic            blank_q;
   logic [HI_W-1:0] cnt_top;
   logic            blank_done;

   assign cnt_top    = wide ? TOP_HI : TOP_LO;
   assign blank_done = blank_q && (bcnt_q == LAST_BLK);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         line_q  <= '0;
         cnt_q   <= '0;
         bcnt_q  <= '0;
         blank_q <= 1'b0;
      end else if (!blank_q) begin
         if (cnt_q == cnt_top) begin
            blank_q <= 1'b1;
            bcnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + HI_W'(1);
         end
      end else if (blank_done) begin
         blank_q <= 1'b0;
         cnt_q   <= '0;
         line_q  <= (line_q == LAST_LINE) ? '0 : line_q + LN_W'(1);
      end else begin
         bcnt_q <= bcnt_q + BK_W'(1);
      end
   end

   assign line      = line_q;
   assign cnt       = cnt_q;
   assign active    = en && !blank_q;
   assign frame_end = en && blank_done && (line_q == LAST_LINE);

   // After a blanking gap the next line follows in order (R1).
   assert_line_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && $fell(blank_q)) |->
      (line_q == (($past(line_q) == LAST_LINE) ? '0 : $past(line_q) + LN_W'(1))));
   // Narrow mode keeps the counter within the narrow period (R5).
   assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !wide) |-> (cnt_q <= TOP_LO));

endmodule

// File: rtl/lsc_column.sv
// One sink column: width select, group scaling and PWM compare.
module lsc_column
   import lsc_pkg::*;
#(
   parameter int HI_W  = 16,
   parameter int LO_W  = 8,
   parameter int NGRP  = 3,
   parameter int GRP_W = 2,
   localparam int GI_W = (NGRP > 1) ? $clog2(NGRP) : 1,
   localparam int PR_W = HI_W + GDUTY_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [HI_W-1:0]     duty,
   input  logic [GRP_W-1:0]    grp,
   input  logic [GAIN_W-1:0]   gain,
   input  logic [GDUTY_W-1:0]  gduty [NGRP],
   input  logic                wide,
   input  logic [HI_W-1:0]     cnt,
   input  logic                active,
   output logic                sink,
   output logic [GAIN_W-1:0]   gain_out
);

   logic [HI_W-1:0]    dsel;
   logic [GRP_W-1:0]   gidx_full;
   logic [GI_W-1:0]    gidx;
   logic               mapped;
   logic [PR_W-1:0]    prod;
   logic [HI_W-1:0]    eff;

   generate
      if (GRP_W > GI_W) begin : g_idx_trim
         logic [GRP_W-1:0] grp_m1;
         assign grp_m1 = grp - GRP_W'(1);
         assign gidx   = grp_m1[GI_W-1:0];
      end else begin : g_idx_pad
         assign gidx = GI_W'(grp - GRP_W'(1));
      end
   endgenerate
   assign gidx_full = grp;

   assign dsel   = wide ? duty : HI_W'(duty[LO_W-1:0]);
   assign mapped = (gidx_full != '0) && (int'(gidx_full) <= NGRP);
   assign prod   = PR_W'(dsel) * PR_W'(gduty[gidx]);
   assign eff    = mapped ? prod[PR_W-1:GDUTY_W] : dsel;

   assign sink     = active && (cnt < eff);
   assign gain_out = active ? gain : '0;

   // A dot programmed with zero duty never lights (R6).
   assert_zero_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (duty == '0) |-> !sink);

endmodule

// File: rtl/led_matrix_scanner.sv
module led_matrix_scanner
   import lsc_pkg::*;
#(
   parameter int     LINES      = 4,
   parameter int     COLS       = 18,
   parameter int     LO_W       = 8,
   parameter int     HI_W       = 16,
   parameter int     BLANK      = 4,
   parameter int     NGRP       = 3,
   parameter longint CLK_HZ     = 100_000_000,
   parameter longint MIN_PWM_HZ = 20_000,
   localparam int DOTS   = LINES * COLS,
   localparam int IDX_W  = $clog2(DOTS),
   localparam int ADDR_W = 2 + IDX_W,
   localparam int WD_W   = (HI_W > GAIN_W) ? HI_W : GAIN_W,
   localparam int GRP_W  = $clog2(NGRP + 1),
   localparam int LN_W   = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [WD_W-1:0]          wr_data,
   output logic [LINES-1:0]         line_on,
   output logic [COLS-1:0]          sink_on,
   output logic [COLS*GAIN_W-1:0]   sink_gain
);

   localparam longint FRAME_CYC = longint'(LINES) * ((longint'(1) << LO_W) + longint'(BLANK));

   generate
      if (LINES < 2 || COLS < 1)    begin : g_bad_geom  $error("matrix needs two or more lines"); end
      if (LO_W < 1 || LO_W >= HI_W) begin : g_bad_width $error("LO_W must be below HI_W"); end
      if (BLANK < 1)                begin : g_bad_blank $error("BLANK must be at least 1"); end
      if (NGRP < 1)                 begin : g_bad_grp   $error("NGRP must be at least 1"); end
      if (CLK_HZ / FRAME_CYC < MIN_PWM_HZ) begin : g_bad_rate
         $error("clock too slow for the minimum PWM repetition rate");
      end
   endgenerate

   logic [HI_W-1:0]    act_duty  [DOTS];
   logic [GAIN_W-1:0]  act_gain  [DOTS];
   logic [GRP_W-1:0]   act_grp   [DOTS];
   logic [GDUTY_W-1:0] act_gduty [NGRP];
   logic               act_wide;

   logic [LN_W-1:0]    line;
   logic [HI_W-1:0]    cnt;
   logic               active;
   logic               frame_end;
   logic               commit;

   assign commit = !en || frame_end;

   lsc_regfile #(
      .DOTS(DOTS), .IDX_W(IDX_W), .HI_W(HI_W), .WD_W(WD_W),
      .NGRP(NGRP), .GRP_W(GRP_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_region (reg_region_e'(wr_addr[ADDR_W-1:ADDR_W-2])),
      .wr_idx    (wr_addr[IDX_W-1:0]),
      .wr_data   (wr_data),
      .commit    (commit),
      .act_duty  (act_duty),
      .act_gain  (act_gain),
      .act_grp   (act_grp),
      .act_gduty (act_gduty),
      .act_wide  (act_wide)
   );

   lsc_sequencer #(
      .LINES(LINES), .LO_W(LO_W), .HI_W(HI_W), .BLANK(BLANK)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .wide      (act_wide),
      .line      (line),
      .cnt       (cnt),
      .active    (active),
      .frame_end (frame_end)
   );

   assign line_on = active ? (LINES'(1) << line) : '0;

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [IDX_W-1:0]  dot_i;
      logic [GAIN_W-1:0] gain_c;

      assign dot_i = IDX_W'(line) * IDX_W'(COLS) + IDX_W'(c);

      lsc_column #(
         .HI_W(HI_W), .LO_W(LO_W), .NGRP(NGRP), .GRP_W(GRP_W)
      ) u_col (
         .clk      (clk),
         .rst_n    (rst_n),
         .duty     (act_duty[dot_i]),
         .grp      (act_grp[dot_i]),
         .gain     (act_gain[dot_i]),
         .gduty    (act_gduty),
         .wide     (act_wide),
         .cnt      (cnt),
         .active   (active),
         .sink     (sink_on[c]),
         .gain_out (gain_c)
      );

      assign sink_gain[c*GAIN_W +: GAIN_W] = gain_c;
   end

   // At most one line switch closed at a time (R1).
   assert_line_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(line_on));
   // No sink or gain while every line is open, as in blanking (R2).
   assert_blank_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_on == '0) |-> ((sink_on == '0) && (sink_gain == '0)));
   // Disabled scan drives nothing (R9).
   assert_disable_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> ((line_on == '0) && (sink_on == '0)));

endmodule

// File: tb/led_matrix_scanner_tb.sv
module led_matrix_scanner_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LINES = 4;
   localparam int COLS  = 18;
   localparam int LO_W  = 2;
   localparam int HI_W  = 4;
   localparam int BLANK = 2;
   localparam int NGRP  = 3;
   localparam int DOTS  = LINES * COLS;
   localparam int IDX_W = 7;
   localparam int ADDR_W = 9;
   localparam int WD_W  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [WD_W-1:0]   wr_data = '0;
   logic [LINES-1:0]  line_on;
   logic [COLS-1:0]   sink_on;
   logic [COLS*8-1:0] sink_gain;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   string cur_tag = "R10";
   int unsigned seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   led_matrix_scanner #(
      .LINES(LINES), .COLS(COLS), .LO_W(LO_W), .HI_W(HI_W),
      .BLANK(BLANK), .NGRP(NGRP)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .line_on(line_on), .sink_on(sink_on), .sink_gain(sink_gain)
   );

   // Reference model built from the requirements.
   int sh_duty [DOTS], sh_gain [DOTS], sh_grp [DOTS], sh_gd [NGRP], sh_wide;
   int m_duty  [DOTS], m_gain  [DOTS], m_grp  [DOTS], m_gd  [NGRP], m_wide;
   int m_line, m_cnt, m_blank, m_bcnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DOTS; i++) begin
            sh_duty[i] = 0; sh_gain[i] = 0; sh_grp[i] = 0;
            m_duty[i] = 0;  m_gain[i] = 0;  m_grp[i] = 0;
         end
         for (int g = 0; g < NGRP; g++) begin sh_gd[g] = 0; m_gd[g] = 0; end
         sh_wide = 0; m_wide = 0;
         m_line = 0; m_cnt = 0; m_blank = 0; m_bcnt = 0;
      end else begin
         automatic bit commit = !en || (m_blank == 1 && m_bcnt == BLANK-1 && m_line == LINES-1);
         automatic int top = m_wide ? (1 << HI_W) - 1 : (1 << LO_W) - 1;
         if (!en) begin
            m_line = 0; m_cnt = 0; m_blank = 0; m_bcnt = 0;
         end else if (m_blank == 0) begin
            if (m_cnt == top) begin m_blank = 1; m_bcnt = 0; end
            else m_cnt++;
         end else if (m_bcnt == BLANK-1) begin
            m_blank = 0; m_cnt = 0; m_line = (m_line + 1) % LINES;
         end else m_bcnt++;
         if (commit) begin
            for (int i = 0; i < DOTS; i++) begin
               m_duty[i] = sh_duty[i]; m_gain[i] = sh_gain[i]; m_grp[i] = sh_grp[i];
            end
            for (int g = 0; g < NGRP; g++) m_gd[g] = sh_gd[g];
            m_wide = sh_wide;
         end
         if (wr_en) begin
            automatic int reg_r = int'(wr_addr[8:7]);
            automatic int idx = int'(wr_addr[6:0]);
            automatic int d = int'(wr_data);
            if (reg_r == 0 && idx < DOTS) sh_duty[idx] = d & 15;
            if (reg_r == 1 && idx < DOTS) sh_gain[idx] = d & 255;
            if (reg_r == 2 && idx < DOTS) sh_grp[idx]  = d & 3;
            if (reg_r == 3 && idx == 0) sh_wide = d & 1;
            if (reg_r == 3 && idx >= 1 && idx <= NGRP) sh_gd[idx-1] = d & 255;
         end
      end
   end

   task automatic check_outputs();
      automatic bit act = (en && rst_n && m_blank == 0);
      automatic logic [LINES-1:0] e_line = act ? LINES'(1 << m_line) : '0;
      automatic logic [COLS-1:0] e_sink = '0;
      automatic logic [COLS*8-1:0] e_gain = '0;
      for (int c = 0; c < COLS; c++) begin
         automatic int dot = m_line * COLS + c;
         automatic int d = m_wide ? m_duty[dot] : (m_duty[dot] & ((1 << LO_W) - 1));
         automatic int eff = (m_grp[dot] == 0) ? d : (d * m_gd[m_grp[dot]-1]) >> 8;
         e_sink[c] = act && (m_cnt < eff);
         e_gain[c*8 +: 8] = act ? 8'(m_gain[dot]) : 8'd0;
      end
      n_chk++;
      if (line_on !== e_line) begin
         n_err++;
         $display("FAIL %s line_on actual=%b expected=%b t=%0t",
                  (m_blank != 0) ? "R2" : "R1", line_on, e_line, $time);
      end
      n_chk++;
      if (sink_on !== e_sink) begin
         n_err++;
         $display("FAIL %s sink_on actual=%h expected=%h t=%0t", cur_tag, sink_on, e_sink, $time);
      end
      n_chk++;
      if (sink_gain !== e_gain) begin
         n_err++;
         $display("FAIL R7 sink_gain actual=%h expected=%h t=%0t", sink_gain, e_gain, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      check_outputs();
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr(input int reg_r, input int idx, input int data);
      wr_en = 1'b1;
      wr_addr = ADDR_W'((reg_r << 7) | idx);
      wr_data = WD_W'(data);
      tick();
      wr_en = 1'b0;
   endtask

   function automatic int rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'(seed >> 16);
   endfunction

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      n_chk++;
      if (line_on !== '0 || sink_on !== '0 || sink_gain !== '0) begin
         n_err++;
         $display("FAIL R10 outputs after reset actual=%b/%h expected=0", line_on, sink_on);
      end

      // R11: load through the address map while disabled, plus ignored addresses
      cur_tag = "R11";
      for (int i = 0; i < DOTS; i++) begin
         wr(0, i, (i % 5 == 0) ? 0 : rnd() & 15);
         wr(1, i, rnd() & 255);
      end
      for (int i = DOTS; i < 128; i += 9) wr(0, i, 15);
      wr(3, 5, 8'hAA);
      wr(3, 127, 8'hFF);

      // R3: plain PWM, narrow mode
      cur_tag = "R3";
      en = 1'b1;
      run(3 * LINES * ((1 << LO_W) + BLANK) + 5);

      // R8: writes at every offset of a running frame, including the rollover
      cur_tag = "R8";
      for (int k = 0; k < 2 * LINES * ((1 << LO_W) + BLANK); k++) begin
         wr(0, rnd() % DOTS, rnd() & 15);
         wr(1, rnd() % DOTS, rnd() & 255);
      end
      run(LINES * ((1 << LO_W) + BLANK) * 2);

      // R4: group mapping and scaling in wide mode
      cur_tag = "R4";
      wr(3, 1, 255);
      wr(3, 2, 128);
      wr(3, 3, 37);
      wr(3, 0, 1);
      for (int i = 0; i < DOTS; i++) wr(2, i, i % 4);
      for (int i = 0; i < DOTS; i++) wr(0, i, (i % 7 == 0) ? 0 : rnd() & 15);
      run(3 * LINES * ((1 << HI_W) + BLANK));

      // R5: switch back to narrow width mid-frame, then wide again
      cur_tag = "R5";
      for (int i = 0; i < DOTS; i++) wr(2, i, 0);
      wr(3, 0, 0);
      run(2 * LINES * ((1 << HI_W) + BLANK));
      wr(3, 0, 1);
      run(2 * LINES * ((1 << HI_W) + BLANK));

      // R6: zero duty dots and zero group duty
      cur_tag = "R6";
      for (int c = 0; c < COLS; c++) wr(0, c, 0);
      wr(3, 2, 0);
      for (int i = COLS; i < DOTS; i += 2) wr(2, i, 2);
      run(2 * LINES * ((1 << HI_W) + BLANK));

      // R9: enable drop in the middle of a slot, restart from line 0
      cur_tag = "R9";
      run(23);
      en = 1'b0;
      wr(0, COLS + 1, 9);
      run(4);
      en = 1'b1;
      run(LINES * ((1 << HI_W) + BLANK) + 7);
      en = 1'b0;
      run(3);
      en = 1'b1;
      run(2 * LINES * ((1 << HI_W) + BLANK));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule